// File: doc/BRIEF.md
# Host attention and command issuer

This block sits on the host side of a disk attachment and issues one command per start pulse through the attachment's small register file. It first runs an attention handshake. It turns interrupts off in the control register, waits until the attachment reports not-busy, writes an attention byte that carries the device number, and turns interrupts back on. It then pushes the command words one by one into the command register. Before each following word it waits until the attachment has taken the previous one.

After the last word has been consumed, the issuer waits for the attachment to clear its command-in-progress flag and then pulses `done_o`. Both flag polls have a bounded retry count: after `POLL_LIMIT` failed samples the issuer gives up and pulses an error output instead. The spacing between samples is `POLL_GAP` clock cycles, so one poll can match a slow register path.

The register bus is write-only from this block. Each cycle carries at most one write, given by a strobe, a 2-bit register select and a 16-bit data word. The three status flags arrive as separate input bits.

Top module: `hci_cmd_issuer`

## Requirements
- R1: Register select encoding is 0 = control, 1 = attention, 2 = command. An accepted start produces a control write of 0x0000 in the next cycle. The attention write comes after it, and a control write of 0x0001 (interrupt enable) follows in the cycle right after the attention write.
- R2: Unless the idle check is skipped, the busy flag is sampled once every `POLL_GAP` cycles, with the first sample in the `POLL_GAP`-th cycle after the control-off write. A sample reading not-busy leads to the attention write in the next cycle. If `POLL_LIMIT` samples in a row read busy, `err_idle_o` pulses and neither the attention nor any command word is written.
- R3: When `skip_idle_i` is 1 at start, the attention write follows the control-off write directly, whatever the busy flag shows.
- R4: The attention write data is {8'h00, device[2:0], attention code[4:0]}.
- R5: The first command word carries the command code in bits 4:0, the device in bits 7:5 and the options in bits 15:8. It is then ORed with 0x4000 when the command is long (4 words). A short command has 2 words and adds nothing.
- R6: The words are written in the order first word, `args_i[15:0]`, then for long commands `args_i[31:16]` and `args_i[47:32]`. Each later word is written the cycle after a full-flag sample reads clear.
- R7: If `POLL_LIMIT` full-flag samples in a row after one word read full, `err_slow_o` pulses and no further word is written.
- R8: After the last word is consumed, the in-progress flag is checked every cycle. `done_o` pulses in the cycle after the first cycle in which it reads clear.
- R9: A start while a command is being issued is ignored. `done_o`, `err_idle_o` and `err_slow_o` are single-cycle pulses and are never high together.
- R10: During and after reset, with no start, all outputs are 0.
- R11: The poll spacing and the sample count restart for every word's full-flag wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| attn_code_i | input | 5 | Attention code |
| skip_idle_i | input | 1 | Skip the not-busy check (reset acknowledge) |
| long_cmd_i | input | 1 | 1 = 4-word command, 0 = 2-word command |
| cmd_code_i | input | 5 | Command code |
| dev_i | input | 3 | Device number |
| opts_i | input | 8 | Command options |
| args_i | input | 48 | Argument words 1..3, word 1 in the low bits |
| stat_busy_i | input | 1 | Attachment busy flag |
| stat_cmd_full_i | input | 1 | Command register still full |
| stat_in_prog_i | input | 1 | Command in progress |
| reg_we_o | output | 1 | Register write strobe |
| reg_sel_o | output | 2 | Register select |
| reg_wdata_o | output | 16 | Register write data |
| done_o | output | 1 | Command finished pulse |
| err_idle_o | output | 1 | Not-busy timeout pulse |
| err_slow_o | output | 1 | Command word not consumed pulse |

## Verification
The hardest cases to reach are the two timeouts and the limit boundary. The bench builds the issuer with a short poll limit and a poll spacing above one. An emulated attachment then holds the busy flag, or the full flag after a chosen word, for as long as each scenario needs. A stuck flag drives the sample counter to exactly its limit, and a start pulse injected during a long command exercises the ignore path. The bench model follows its own script of expected writes and waits, and compares every output every cycle.

// File: rtl/hci_pkg.sv
package hci_pkg;
    localparam int WORD_W = 16;
    localparam int ARG_N  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_IDLECHK,
        ST_ATTN,
        ST_UNGATE,
        ST_PUSH,
        ST_PUSHWAIT,
        ST_DRAIN
    } hci_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ATTN = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;

    localparam logic [WORD_W-1:0] CTRL_IRQ_EN   = 16'h0001;
    localparam logic [WORD_W-1:0] LONG_TYPE_BIT = 16'h4000;
endpackage

// File: rtl/hci_poll_timer.sv
module hci_poll_timer #(
    parameter int POLL_GAP   = 4,
    parameter int POLL_LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o,
    output logic expire_o
);
    localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam int PW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [PW-1:0] polls;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        tick_o   = run_i && (t_q.gap == GW'(POLL_GAP - 1));
        expire_o = tick_o && (t_q.polls == PW'(POLL_LIMIT - 1));
        if (!run_i) begin
            t_d = '0;
        end else if (tick_o) begin
            t_d.gap   = '0;
            t_d.polls = t_q.polls + 1'b1;
        end else begin
            t_d.gap = t_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/hci_cmd_format.sv
module hci_cmd_format
    import hci_pkg::*;
(
    input  logic [4:0]              attn_code_i,
    input  logic                    long_cmd_i,
    input  logic [4:0]              cmd_code_i,
    input  logic [2:0]              dev_i,
    input  logic [7:0]              opts_i,
    input  logic [ARG_N*WORD_W-1:0] args_i,
    input  logic [1:0]              idx_i,
    output logic [WORD_W-1:0]       attn_word_o,
    output logic [WORD_W-1:0]       cmd_word_o,
    output logic                    last_o
);
    logic [ARG_N:0][WORD_W-1:0] words;

    assign words[0] = {opts_i, dev_i, cmd_code_i} | (long_cmd_i ? LONG_TYPE_BIT : '0);

    genvar k;
    generate
        for (k = 1; k <= ARG_N; k++) begin : g_arg
            assign words[k] = args_i[k*WORD_W-1 -: WORD_W];
        end
    endgenerate

    assign attn_word_o = {8'h00, dev_i, attn_code_i};
    assign cmd_word_o  = words[idx_i];
    assign last_o      = long_cmd_i ? (idx_i == 2'd3) : (idx_i == 2'd1);
endmodule

// File: rtl/hci_cmd_issuer.sv
module hci_cmd_issuer
    import hci_pkg::*;
#(
    parameter int POLL_GAP   = 4,
    parameter int POLL_LIMIT = 10000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [4:0]  attn_code_i,
    input  logic        skip_idle_i,
    input  logic        long_cmd_i,
    input  logic [4:0]  cmd_code_i,
    input  logic [2:0]  dev_i,
    input  logic [7:0]  opts_i,
    input  logic [47:0] args_i,
    input  logic        stat_busy_i,
    input  logic        stat_cmd_full_i,
    input  logic        stat_in_prog_i,
    output logic        reg_we_o,
    output logic [1:0]  reg_sel_o,
    output logic [15:0] reg_wdata_o,
    output logic        done_o,
    output logic        err_idle_o,
    output logic        err_slow_o
);
    typedef struct packed {
        hci_state_e  state;
        logic [4:0]  attn;
        logic        skip;
        logic        long_cmd;
        logic [4:0]  code;
        logic [2:0]  dev;
        logic [7:0]  opts;
        logic [47:0] args;
        logic [1:0]  idx;
        logic        done;
        logic        err_idle;
        logic        err_slow;
    } issuer_t;

    issuer_t s_d, s_q;

    logic              poll_run, poll_tick, poll_expire;
    logic [WORD_W-1:0] attn_word, cmd_word;
    logic              last_word;

    assign poll_run = (s_q.state == ST_IDLECHK) || (s_q.state == ST_PUSHWAIT);

    hci_poll_timer #(
        .POLL_GAP  (POLL_GAP),
        .POLL_LIMIT(POLL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (poll_run),
        .tick_o  (poll_tick),
        .expire_o(poll_expire)
    );

    hci_cmd_format u_fmt (
        .attn_code_i(s_q.attn),
        .long_cmd_i (s_q.long_cmd),
        .cmd_code_i (s_q.code),
        .dev_i      (s_q.dev),
        .opts_i     (s_q.opts),
        .args_i     (s_q.args),
        .idx_i      (s_q.idx),
        .attn_word_o(attn_word),
        .cmd_word_o (cmd_word),
        .last_o     (last_word)
    );

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.err_idle = 1'b0;
        s_d.err_slow = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.state    = ST_GATE;
                    s_d.attn     = attn_code_i;
                    s_d.skip     = skip_idle_i;
                    s_d.long_cmd = long_cmd_i;
                    s_d.code     = cmd_code_i;
                    s_d.dev      = dev_i;
                    s_d.opts     = opts_i;
                    s_d.args     = args_i;
                    s_d.idx      = '0;
                end
            end
            ST_GATE:    s_d.state = s_q.skip ? ST_ATTN : ST_IDLECHK;
            ST_IDLECHK: begin
                if (poll_tick && !stat_busy_i) begin
                    s_d.state = ST_ATTN;
                end else if (poll_expire) begin
                    s_d.state    = ST_IDLE;
                    s_d.err_idle = 1'b1;
                end
            end
            ST_ATTN:   s_d.state = ST_UNGATE;
            ST_UNGATE: s_d.state = ST_PUSH;
            ST_PUSH:   s_d.state = ST_PUSHWAIT;
            ST_PUSHWAIT: begin
                if (poll_tick && !stat_cmd_full_i) begin
                    if (last_word) begin
                        s_d.state = ST_DRAIN;
                    end else begin
                        s_d.idx   = s_q.idx + 2'd1;
                        s_d.state = ST_PUSH;
                    end
                end else if (poll_expire) begin
                    s_d.state    = ST_IDLE;
                    s_d.err_slow = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!stat_in_prog_i) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_we_o    = 1'b0;
        reg_sel_o   = SEL_CTRL;
        reg_wdata_o = '0;
        unique case (s_q.state)
            ST_GATE:   reg_we_o = 1'b1;
            ST_ATTN: begin
                reg_we_o    = 1'b1;
                reg_sel_o   = SEL_ATTN;
                reg_wdata_o = attn_word;
            end
            ST_UNGATE: begin
                reg_we_o    = 1'b1;
                reg_wdata_o = CTRL_IRQ_EN;
            end
            ST_PUSH: begin
                reg_we_o    = 1'b1;
                reg_sel_o   = SEL_CMD;
                reg_wdata_o = cmd_word;
            end
            default: ;
        endcase
    end

    assign done_o     = s_q.done;
    assign err_idle_o = s_q.err_idle;
    assign err_slow_o = s_q.err_slow;
endmodule

// File: rtl/hci_cmd_issuer_chk.sv
module hci_cmd_issuer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stat_busy_i,
    input logic        stat_cmd_full_i,
    input logic        stat_in_prog_i,
    input logic        reg_we_o,
    input logic [1:0]  reg_sel_o,
    input logic [15:0] reg_wdata_o,
    input logic        done_o,
    input logic        err_idle_o,
    input logic        err_slow_o
);
    logic ctrl_wr, attn_wr, cmd_wr;
    assign ctrl_wr = reg_we_o && (reg_sel_o == 2'd0);
    assign attn_wr = reg_we_o && (reg_sel_o == 2'd1);
    assign cmd_wr  = reg_we_o && (reg_sel_o == 2'd2);

    p_attn_then_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        attn_wr |=> (ctrl_wr && reg_wdata_o == 16'h0001));

    p_attn_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (attn_wr && !$past(ctrl_wr)) |-> $past(!stat_busy_i));

    p_word_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !$past(ctrl_wr)) |-> $past(!stat_cmd_full_i));

    p_done_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(!stat_in_prog_i));

    p_exclusive_pulses_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_idle_o, err_slow_o}));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_quiet_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_idle_o || err_slow_o) |-> !reg_we_o);
endmodule

bind hci_cmd_issuer hci_cmd_issuer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stat_busy_i    (stat_busy_i),
    .stat_cmd_full_i(stat_cmd_full_i),
    .stat_in_prog_i (stat_in_prog_i),
    .reg_we_o       (reg_we_o),
    .reg_sel_o      (reg_sel_o),
    .reg_wdata_o    (reg_wdata_o),
    .done_o         (done_o),
    .err_idle_o     (err_idle_o),
    .err_slow_o     (err_slow_o)
);

// File: tb/hci_cmd_issuer_test.sv
`timescale 1ns/1ps
module hci_cmd_issuer_test;
    localparam int GAP   = 3;
    localparam int LIMIT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  attn_code_i = '0;
    logic        skip_idle_i = 1'b0;
    logic        long_cmd_i = 1'b0;
    logic [4:0]  cmd_code_i = '0;
    logic [2:0]  dev_i = '0;
    logic [7:0]  opts_i = '0;
    logic [47:0] args_i = '0;
    logic        stat_busy_i = 1'b0;
    logic        stat_cmd_full_i = 1'b0;
    logic        stat_in_prog_i = 1'b0;
    logic        reg_we_o;
    logic [1:0]  reg_sel_o;
    logic [15:0] reg_wdata_o;
    logic        done_o, err_idle_o, err_slow_o;

    always #2 clk = ~clk;

    hci_cmd_issuer #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .attn_code_i(attn_code_i),
        .skip_idle_i(skip_idle_i), .long_cmd_i(long_cmd_i), .cmd_code_i(cmd_code_i),
        .dev_i(dev_i), .opts_i(opts_i), .args_i(args_i), .stat_busy_i(stat_busy_i),
        .stat_cmd_full_i(stat_cmd_full_i), .stat_in_prog_i(stat_in_prog_i),
        .reg_we_o(reg_we_o), .reg_sel_o(reg_sel_o), .reg_wdata_o(reg_wdata_o),
        .done_o(done_o), .err_idle_o(err_idle_o), .err_slow_o(err_slow_o)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model: script of writes and waits ----------
    localparam int K_WRITE = 0, K_BUSY = 1, K_FULL = 2, K_PROG = 3;
    int kind_q[$];
    int data_q[$];
    int gap_n = 0, poll_n = 0;
    bit exp_we = 0; int exp_sel = 0; int exp_data = 0;
    bit exp_done = 0, exp_ei = 0, exp_es = 0;

    function automatic int word0(input bit lng, input int code, input int dev, input int opt);
        return (opt << 8) | (dev << 5) | code | (lng ? 32'h4000 : 0);
    endfunction

    always @(posedge clk) begin
        bit idle_before;
        exp_done = 0; exp_ei = 0; exp_es = 0;
        if (!rst_n) begin
            kind_q.delete(); data_q.delete(); gap_n = 0; poll_n = 0;
        end else begin
            idle_before = (kind_q.size() == 0);
            if (idle_before) begin
                if (start_i) begin
                    kind_q.push_back(K_WRITE); data_q.push_back(0);
                    if (!skip_idle_i) begin kind_q.push_back(K_BUSY); data_q.push_back(0); end
                    kind_q.push_back(K_WRITE); data_q.push_back((1 << 16) | {dev_i, attn_code_i});
                    kind_q.push_back(K_WRITE); data_q.push_back(1);
                    for (int w = 0; w < (long_cmd_i ? 4 : 2); w++) begin
                        kind_q.push_back(K_WRITE);
                        data_q.push_back((2 << 16) | ((w == 0) ?
                            word0(long_cmd_i, cmd_code_i, dev_i, opts_i) : args_i[16*w-1 -: 16]));
                        kind_q.push_back(K_FULL); data_q.push_back(0);
                    end
                    kind_q.push_back(K_PROG); data_q.push_back(0);
                    gap_n = 0; poll_n = 0;
                end
            end else if (kind_q[0] == K_WRITE) begin
                void'(kind_q.pop_front()); void'(data_q.pop_front());
            end else if (kind_q[0] == K_PROG) begin
                if (!stat_in_prog_i) begin
                    kind_q.delete(); data_q.delete(); exp_done = 1;
                end
            end else begin
                gap_n++;
                if (gap_n == GAP) begin
                    gap_n = 0; poll_n++;
                    if (!((kind_q[0] == K_BUSY) ? stat_busy_i : stat_cmd_full_i)) begin
                        void'(kind_q.pop_front()); void'(data_q.pop_front());
                        poll_n = 0;
                    end else if (poll_n == LIMIT) begin
                        if (kind_q[0] == K_BUSY) exp_ei = 1; else exp_es = 1;
                        kind_q.delete(); data_q.delete(); poll_n = 0;
                    end
                end
            end
        end
        exp_we = (kind_q.size() != 0) && (kind_q[0] == K_WRITE);
        exp_sel = exp_we ? (data_q[0] >> 16) : 0;
        exp_data = exp_we ? (data_q[0] & 32'hFFFF) : 0;
    end

    // ---------------- attachment emulation and per-cycle compare ----------
    int busy_left = 0; bit busy_stuck = 0;
    int full_hold = 1; int full_left = 0; bit full_stuck = 0;
    int prog_hold = 3; int prog_left = 0;
    int n_attn = 0, n_cmd = 0, n_done = 0, n_ei = 0, n_es = 0;
    int cur_w0 = 0, cur_attn = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if ({reg_we_o, reg_sel_o, reg_wdata_o, done_o, err_idle_o, err_slow_o} !==
                {exp_we, 2'(exp_sel), 16'(exp_data), exp_done, exp_ei, exp_es}) begin
                failures++;
                $display("FAIL R1 R6 trace t=%0t actual=%b/%0d/%h/%b%b%b expected=%b/%0d/%h/%b%b%b",
                    $time, reg_we_o, reg_sel_o, reg_wdata_o, done_o, err_idle_o, err_slow_o,
                    exp_we, exp_sel, exp_data[15:0], exp_done, exp_ei, exp_es);
            end
            if (reg_we_o && reg_sel_o == 2'd1) begin
                n_attn++;
                check("R4 attention data", reg_wdata_o, cur_attn);
            end
            if (reg_we_o && reg_sel_o == 2'd2) begin
                if (n_cmd == 0) check("R5 first word", reg_wdata_o, cur_w0);
                n_cmd++;
                full_left = full_hold;
                prog_left = full_hold * GAP + prog_hold + 2;
            end
            n_done += done_o; n_ei += err_idle_o; n_es += err_slow_o;
        end
        stat_busy_i = busy_stuck || (busy_left > 0);
        if (busy_left > 0) busy_left--;
        stat_cmd_full_i = full_stuck || (full_left > 0);
        if (full_left > 0) full_left--;
        stat_in_prog_i = (prog_left > 0);
        if (prog_left > 0) prog_left--;
    end

    task automatic issue(input bit skip, input bit lng, input int code, input int dev,
                         input int opt, input logic [47:0] args, input int attn);
        @(negedge clk);
        start_i = 1; skip_idle_i = skip; long_cmd_i = lng; cmd_code_i = 5'(code);
        dev_i = 3'(dev); opts_i = 8'(opt); args_i = args; attn_code_i = 5'(attn);
        cur_w0 = word0(lng, code, dev, opt);
        cur_attn = (dev << 5) | attn;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic scenario(input int busy_c, input bit bstuck, input int fhold,
                            input bit fstuck, input int phold);
        busy_left = busy_c; busy_stuck = bstuck; full_hold = fhold;
        full_stuck = fstuck; prog_hold = phold;
        n_attn = 0; n_cmd = 0; n_done = 0; n_ei = 0; n_es = 0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (n_done + n_ei + n_es != 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset we", reg_we_o, 0);
        check("R10 reset done", {done_o, err_idle_o, err_slow_o}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check("R10 idle outputs", {reg_we_o, reg_wdata_o}, 0);

        // short command, attachment idle
        scenario(0, 0, 1, 0, 4);
        issue(0, 0, 5'h05, 1, 8'h00, 48'h0000_0000_1234, 3);
        wait_end();
        check("R8 done short", n_done, 1);
        check("R6 short word count", n_cmd, 2);

        // long read, busy for a while, slow word consumption (R11 restart per word)
        scenario(10, 0, 4, 0, 6);
        issue(0, 1, 5'h01, 0, 8'h02, 48'hCAFE_0003_0010, 3);
        wait_end();
        check("R11 long done", n_done, 1);
        check("R6 long word count", n_cmd, 4);
        check("R2 attention once", n_attn, 1);

        // skip idle check with busy stuck
        scenario(0, 1, 1, 0, 2);
        issue(1, 0, 5'h1F, 7, 8'hA5, 48'h0000_0000_BEEF, 5'h12);
        wait_end();
        check("R3 skip idle done", n_done, 1);
        check("R3 attention written", n_attn, 1);

        // busy stuck, no skip: idle timeout
        scenario(0, 1, 1, 0, 2);
        issue(0, 0, 5'h02, 2, 8'h11, 48'h0, 1);
        wait_end();
        check("R2 idle timeout pulse", n_ei, 1);
        check("R2 no attention on timeout", n_attn, 0);
        check("R2 no words on timeout", n_cmd, 0);

        // full stuck: too slow
        scenario(0, 0, 1, 1, 2);
        issue(0, 1, 5'h02, 1, 8'h02, 48'h1111_2222_3333, 3);
        wait_end();
        check("R7 slow pulse", n_es, 1);
        check("R7 one word only", n_cmd, 1);
        check("R9 no done on error", n_done, 0);

        // start while busy is ignored
        scenario(6, 0, 3, 0, 5);
        issue(0, 1, 5'h01, 1, 8'h02, 48'h0A0A_0B0B_0C0C, 3);
        repeat (5) @(negedge clk);
        start_i = 1; cmd_code_i = 5'h09; dev_i = 3'd6; skip_idle_i = 1;
        @(negedge clk);
        start_i = 0;
        wait_end();
        check("R9 single done", n_done, 1);
        check("R9 words of first cmd only", n_cmd, 4);
        check("R9 single attention", n_attn, 1);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule